// File: doc/BRIEF.md
# Frame Pulse and Aligned Clock Generator

This block turns a 16.384 MHz master clock into a set of timing outputs that share one 125 us (8 kHz) frame. It gives three frame markers: a 4-cycle active-low pulse, a 2-cycle active-high pulse and a 1-cycle active-low pulse. It also gives 8.192, 4.096 and 2.048 MHz clocks. All of these come from a single frame counter, so they keep a fixed phase to one another.

Each frame marker is centred on the point where the counter wraps, so it straddles the frame boundary. Each divided clock rises at the first count of a frame. A one-cycle resync strobe moves the frame boundary to the cycle that follows the strobe. After reset the markers stay in their idle levels until the first frame boundary, so no part-width pulse can leave the block.

Top module: `frame_pulse_gen`

## Requirements
- R1: The frame counter has 2048 states (0 to 2047) and steps once per master cycle. After 2047 it returns to 0, so each marker repeats every 2048 cycles.
- R2: `fp_wide_n` is low while the count is 2046, 2047, 0 or 1 and high at all other counts, giving a 4-cycle low pulse.
- R3: `fp_mid` is high while the count is 2047 or 0 and low at all other counts, giving a 2-cycle high pulse.
- R4: `fp_narrow_n` is low only while the count is 0, giving a 1-cycle low pulse.
- R5: `clk_8m`, `clk_4m` and `clk_2m` equal the inverse of count bits 0, 1 and 2. Each has a 50% duty cycle, and all three are high at count 0.
- R6: If `resync_i` is high at a clock edge and reset is not, the count is 0 in the next cycle and the markers are armed.
- R7: From reset until the first frame boundary, `fp_wide_n` and `fp_narrow_n` stay high and `fp_mid` stays low. The first boundary is either the 2047-to-0 wrap or a resync.
- R8: While `rst` is high at a clock edge, the count is set to 0 and the markers are disarmed. The outputs then read markers idle and all three clocks high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| resync_i | input | 1 | One-cycle strobe that restarts the frame |
| fp_wide_n | output | 1 | 4-cycle active-low frame marker |
| fp_mid | output | 1 | 2-cycle active-high frame marker |
| fp_narrow_n | output | 1 | 1-cycle active-low frame marker |
| clk_8m | output | 1 | 8.192 MHz frame-aligned clock |
| clk_4m | output | 1 | 4.096 MHz frame-aligned clock |
| clk_2m | output | 1 | 2.048 MHz frame-aligned clock |

## Verification
The bench checks the pulse windows on both sides of the wrap. If a window is off by one, the wide or mid pulse moves entirely to one side of count 0 and the straddle is lost.

Resync strobes are placed on the last count, on count 0, on count 1 and at random phases. A design that delays the restart by one cycle, or that does not arm on a resync, shows the narrow pulse a cycle late or not at all.

The first frame after reset is checked cycle by cycle for idle markers. A missing arm flag would put out the tail of a wide pulse at counts 0 and 1.

The spacing between two narrow pulses is measured. A counter that skips a state or stops one count short gives a spacing other than 2048.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    // Frame geometry
    localparam int unsigned FRAME_BITS = 11;
    localparam int unsigned FRAME_LEN  = 1 << FRAME_BITS;

    // Marker set: index 0 wide, 1 mid, 2 narrow
    localparam int unsigned NUM_MARKERS = 3;
    localparam int unsigned MARKER_W [NUM_MARKERS] = '{4, 2, 1};
    localparam bit          MARKER_LOW [NUM_MARKERS] = '{1'b1, 1'b0, 1'b1};

    // Number of divided clocks taken from low counter bits
    localparam int unsigned NUM_DIV = 3;

    typedef logic [FRAME_BITS-1:0] frame_cnt_t;

    typedef struct packed {
        logic       armed;
        frame_cnt_t cnt;
    } frame_state_t;

    // Shift that moves a centred window of width w to start at zero
    function automatic frame_cnt_t centre_shift(input int unsigned w);
        return frame_cnt_t'(w / 2);
    endfunction

endpackage

// File: rtl/frame_counter.sv
module frame_counter
    import fpg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         resync_i,
    output frame_state_t st_o
);
    localparam frame_cnt_t LAST = frame_cnt_t'(FRAME_LEN - 1);

    frame_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= '0;
            st_q.armed <= 1'b0;
        end else if (resync_i || st_q.cnt == LAST) begin
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q.cnt   <= st_q.cnt + frame_cnt_t'(1);
        end
    end

    assign st_o = st_q;

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!resync_i && st_q.cnt == LAST) |=> (st_q.cnt == '0 && st_q.armed));

    // R1
    step_once_chk: assert property (@(posedge clk) disable iff (rst)
        (!resync_i && st_q.cnt != LAST) |=> (st_q.cnt == $past(st_q.cnt) + frame_cnt_t'(1)));

    // R6
    resync_restart_chk: assert property (@(posedge clk) disable iff (rst)
        resync_i |=> (st_q.cnt == '0 && st_q.armed));

endmodule

// File: rtl/marker_shaper.sv
module marker_shaper
    import fpg_pkg::*;
#(
    parameter int unsigned WIDTH      = 1,
    parameter bit          ACTIVE_LOW = 1'b1
) (
    input  frame_state_t st_i,
    output logic         marker_o
);
    localparam frame_cnt_t SHIFT = centre_shift(WIDTH);
    localparam frame_cnt_t SPAN  = frame_cnt_t'(WIDTH);

    frame_cnt_t shifted;
    logic       active;

    always_comb begin
        shifted  = st_i.cnt + SHIFT;
        active   = st_i.armed && (shifted < SPAN);
        marker_o = ACTIVE_LOW ? ~active : active;
    end

endmodule

// File: rtl/clock_divider.sv
module clock_divider #(
    parameter int unsigned NCLK = 3
) (
    input  logic [NCLK-1:0] cnt_low_i,
    output logic [NCLK-1:0] clk_o
);
    for (genvar k = 0; k < NCLK; k++) begin : g_div
        assign clk_o[k] = ~cnt_low_i[k];
    end
endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
    import fpg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic resync_i,
    output logic fp_wide_n,
    output logic fp_mid,
    output logic fp_narrow_n,
    output logic clk_8m,
    output logic clk_4m,
    output logic clk_2m
);
    frame_state_t           st;
    logic [NUM_MARKERS-1:0] markers;
    logic [NUM_DIV-1:0]     div_clks;

    frame_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .resync_i (resync_i),
        .st_o     (st)
    );

    for (genvar m = 0; m < NUM_MARKERS; m++) begin : g_marker
        marker_shaper #(
            .WIDTH      (MARKER_W[m]),
            .ACTIVE_LOW (MARKER_LOW[m])
        ) u_shape (
            .st_i     (st),
            .marker_o (markers[m])
        );
    end

    clock_divider #(.NCLK(NUM_DIV)) u_div (
        .cnt_low_i (st.cnt[NUM_DIV-1:0]),
        .clk_o     (div_clks)
    );

    assign fp_wide_n   = markers[0];
    assign fp_mid      = markers[1];
    assign fp_narrow_n = markers[2];
    assign clk_8m      = div_clks[0];
    assign clk_4m      = div_clks[1];
    assign clk_2m      = div_clks[2];

    // R4
    narrow_inside_mid_chk: assert property (@(posedge clk) disable iff (rst)
        !fp_narrow_n |-> fp_mid);

    // R3
    mid_inside_wide_chk: assert property (@(posedge clk) disable iff (rst)
        fp_mid |-> !fp_wide_n);

    // R5
    clocks_high_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !fp_narrow_n |-> (clk_8m && clk_4m && clk_2m));

    // R7
    idle_until_armed_chk: assert property (@(posedge clk) disable iff (rst)
        !st.armed |-> (fp_wide_n && !fp_mid && fp_narrow_n));

endmodule

// File: tb/frame_pulse_gen_test.sv
module frame_pulse_gen_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic resync_i = 1'b0;
    logic fp_wide_n, fp_mid, fp_narrow_n, clk_8m, clk_4m, clk_2m;

    int unsigned n_vec  = 0;
    int unsigned n_bad  = 0;
    bit          done   = 1'b0;

    // Reference state derived from the requirements
    int unsigned m_cnt   = 0;
    bit          m_armed = 1'b0;

    always #2.5 clk = ~clk;

    frame_pulse_gen uut (
        .clk(clk), .rst(rst), .resync_i(resync_i),
        .fp_wide_n(fp_wide_n), .fp_mid(fp_mid), .fp_narrow_n(fp_narrow_n),
        .clk_8m(clk_8m), .clk_4m(clk_4m), .clk_2m(clk_2m)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt   <= 0;
            m_armed <= 1'b0;
        end else if (resync_i || m_cnt == 2047) begin
            m_cnt   <= 0;
            m_armed <= 1'b1;
        end else begin
            m_cnt   <= m_cnt + 1;
        end
    end

    function automatic bit exp_wide_n(int unsigned c, bit a);
        return !(a && (c == 2046 || c == 2047 || c == 0 || c == 1));
    endfunction
    function automatic bit exp_mid(int unsigned c, bit a);
        return a && (c == 2047 || c == 0);
    endfunction
    function automatic bit exp_narrow_n(int unsigned c, bit a);
        return !(a && c == 0);
    endfunction
    function automatic bit [2:0] exp_clks(int unsigned c);
        return {(c % 8) < 4, (c % 4) < 2, (c % 2) == 0};
    endfunction

    task automatic check_bit(string tag, string what, logic act, logic exp);
        if (act !== exp) begin
            n_bad++;
            if (n_bad < 40)
                $display("FAIL %s %s at count %0d: got %b expected %b", tag, what, m_cnt, act, exp);
        end
    endtask

    // Compare every output against the model; called just after a falling edge
    task automatic check_cycle();
        string tm;
        n_vec++;
        tm = m_armed ? "" : " R7";
        check_bit({"R2", tm}, "fp_wide_n",   fp_wide_n,   exp_wide_n(m_cnt, m_armed));
        check_bit({"R3", tm}, "fp_mid",      fp_mid,      exp_mid(m_cnt, m_armed));
        check_bit({"R4", tm}, "fp_narrow_n", fp_narrow_n, exp_narrow_n(m_cnt, m_armed));
        check_bit("R5", "clocks", 1'b0, 1'b0);
        if ({clk_2m, clk_4m, clk_8m} !== exp_clks(m_cnt)) begin
            n_bad++;
            if (n_bad < 40)
                $display("FAIL R5 clocks at count %0d: got %b expected %b",
                         m_cnt, {clk_2m, clk_4m, clk_8m}, exp_clks(m_cnt));
        end
    endtask

    task automatic run(int unsigned cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check_cycle();
        end
    endtask

    // Pulse resync for one cycle once the model count reaches target
    task automatic resync_at(int unsigned target);
        do begin
            @(negedge clk);
            check_cycle();
        end while (m_cnt != target);
        resync_i = 1'b1;
        @(negedge clk);
        resync_i = 1'b0;
        n_vec++;
        // R6: count restarts at 0 and narrow marker fires
        if (fp_narrow_n !== 1'b0 || fp_mid !== 1'b1) begin
            n_bad++;
            $display("FAIL R6 after resync at %0d: narrow_n=%b mid=%b expected 0 1",
                     target, fp_narrow_n, fp_mid);
        end
        check_cycle();
    endtask

    initial begin
        int unsigned seed;
        int unsigned gap;
        seed = $urandom(32'd20240611);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset state
        n_vec++;
        if ({fp_wide_n, fp_mid, fp_narrow_n, clk_8m, clk_4m, clk_2m} !== 6'b101111) begin
            n_bad++;
            $display("FAIL R8 reset outputs: got %b expected 101111",
                     {fp_wide_n, fp_mid, fp_narrow_n, clk_8m, clk_4m, clk_2m});
        end
        check_cycle();
        rst = 1'b0;

        // R7: first frame idle, then first boundary
        run(2100);

        // R1: spacing between narrow pulses
        while (fp_narrow_n !== 1'b0) begin @(negedge clk); check_cycle(); end
        gap = 0;
        do begin
            @(negedge clk);
            check_cycle();
            gap++;
        end while (fp_narrow_n !== 1'b0 && gap < 5000);
        n_vec++;
        if (gap != 2048) begin
            n_bad++;
            $display("FAIL R1 frame spacing: got %0d expected 2048", gap);
        end

        // R6: directed resync phases
        resync_at(2047);
        resync_at(0);
        resync_at(1);
        resync_at(5);
        resync_at(1000);
        run(2100);

        // Random resync strobes
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            check_cycle();
            resync_i = ($urandom % 3000) == 0;
        end
        resync_i = 1'b0;

        // Reset mid frame, then resync before the first wrap (R7, R6)
        run(300);
        rst = 1'b1;
        @(negedge clk);
        check_cycle();
        rst = 1'b0;
        run(700);
        resync_at(800);
        run(4200);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule